// File: doc/BRIEF.md
# Scrambled SLIP Frame Decoder

This block takes bytes from a parallel byte link and rebuilds the packets that a matching encoder framed with SLIP-style byte stuffing. Before stuffing, the encoder whitened every payload byte by XOR with an LFSR keystream. Whitening keeps long runs of one value, such as a constant sample, from turning into runs of escaped bytes. The decoder undoes the two steps in reverse order. A one-bit escape state machine first recovers each data byte. The recovered byte is then XORed with the same keystream, which advances only when a data byte is produced.

Every delimiter byte closes the current packet and reseeds the keystream, so a receiver that lost or duplicated bytes is back in step at the next delimiter. A one-byte holding register delays each recovered byte until the decoder knows whether the next symbol is data or a delimiter, so the final payload byte can carry the last marker. A malformed escape raises a one-cycle error pulse. It also drops the held byte and mutes the output until the next delimiter.

Top module: `slipDescrambler`

## Requirements
- R1: An input byte that is neither 0xC0 (delimiter) nor 0xDB (escape), received outside an escape, is forwarded as that byte XOR the current key byte.
- R2: After 0xDB, the byte 0xDC recovers the value 0xC0 and the byte 0xDD recovers the value 0xDB. Each recovered value is XORed with the key and forwarded like any other data byte.
- R3: After 0xDB, any byte other than 0xDC, 0xDD or 0xC0 raises errPulse for exactly one cycle, in the cycle after that byte is accepted. The byte still held is discarded.
- R4: After an R3 error, every input byte up to and including the next 0xC0 produces no output. The packet that follows decodes with a freshly seeded keystream.
- R5: The keystream comes from a 16-bit Fibonacci LFSR with seed 0xACE1. Each step shifts left and inserts the XOR of state bits 15, 13, 12 and 10 at bit 0. The key byte is the low 8 bits of the state. The state advances 8 steps after each forwarded data byte and returns to the seed on every 0xC0.
- R6: When a 0xC0 ends a packet that holds data, the final payload byte is output with outLast high. All earlier bytes of that packet have outLast low.
- R7: A 0xC0 with no data since the previous delimiter produces no output and no error.
- R8: A 0xC0 received inside an escape raises errPulse and discards the held byte. It does not mute the packet that follows.
- R9: While outValid is high and outReady is low, outData, outLast and outValid hold steady. inReady is high exactly when the output register is empty or is being taken this cycle.
- R10: After reset, outValid and errPulse are low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Stuffed, scrambled link byte |
| inValid | input | 1 | inByte is present |
| inReady | output | 1 | Decoder accepts inByte this cycle |
| outData | output | 8 | Recovered payload byte |
| outLast | output | 1 | outData is the final byte of its packet |
| outValid | output | 1 | outData is present |
| outReady | input | 1 | Consumer takes outData this cycle |
| errPulse | output | 1 | One-cycle malformed-escape indication |

## Verification
The hardest cases to reach are the escaped data bytes. The link carries 0xDB 0xDC or 0xDB 0xDD only when the scrambled value happens to be 0xC0 or 0xDB, which depends on the keystream position. To force these cases, the bench computes the keystream itself and picks payload bytes that scramble onto those two values. Errors are placed at random positions inside packets, including directly before a delimiter. This checks that the held byte is dropped and that the decoder resynchronises, under random gaps on the input and random backpressure on the output.

// File: rtl/slipDecPkg.sv
package slipDecPkg;

  localparam logic [7:0] DELIM_CODE   = 8'hC0;
  localparam logic [7:0] ESCAPE_CODE  = 8'hDB;
  localparam logic [7:0] ESC_DELIM    = 8'hDC;
  localparam logic [7:0] ESC_ESCAPE   = 8'hDD;

  typedef enum logic [1:0] {
    SEL_RAW    = 2'd0,
    SEL_DELIM  = 2'd1,
    SEL_ESCAPE = 2'd2
  } byteSel_e;

  typedef enum logic {
    ST_PLAIN   = 1'b0,
    ST_ESCAPED = 1'b1
  } escState_e;

  typedef struct packed {
    logic     advance;
    logic     reseed;
    logic     loadHold;
    logic     pushHold;
    logic     pushLast;
    byteSel_e sel;
  } dpStrobe_t;

endpackage

// File: rtl/slipKeystream.sv
module slipKeystream #(
  parameter int          STATE_W = 16,
  parameter int          KEY_W   = 8,
  parameter logic [15:0] TAPS    = 16'hB400,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic             reseed,
  output logic [KEY_W-1:0] key
);

  localparam logic [STATE_W-1:0] SEED_V = SEED[STATE_W-1:0];
  localparam logic [STATE_W-1:0] TAP_V  = TAPS[STATE_W-1:0];

  logic [STATE_W-1:0] state;
  logic [STATE_W-1:0] stepped [KEY_W+1];

  assign stepped[0] = state;

  generate
    for (genvar i = 0; i < KEY_W; i++) begin : g_step
      assign stepped[i+1] = {stepped[i][STATE_W-2:0], ^(stepped[i] & TAP_V)};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)        state <= SEED_V;
    else if (reseed)  state <= SEED_V;
    else if (advance) state <= stepped[KEY_W];
  end

  assign key = state[KEY_W-1:0];

  // R5: a delimiter puts the generator back at the seed
  p_reseed_to_seed_r5: assert property (@(posedge clk) disable iff (!rstN)
    reseed |=> state == SEED_V);

  // R5: the state only moves on a forwarded byte or a delimiter
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!reseed && !advance) |=> $stable(state));

endmodule

// File: rtl/slipCtrl.sv
module slipCtrl
  import slipDecPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       inValid,
  input  logic       outFree,
  output logic       inReady,
  output dpStrobe_t  strobes,
  output logic       errPulse
);

  escState_e escState, escNext;
  logic      muted, mutedNext;
  logic      holdValid, holdValidNext;
  logic      errNext;
  logic      accept;
  logic      takeData;
  byteSel_e  dataSel;

  assign inReady = outFree;
  assign accept  = inValid && outFree;

  always_comb begin
    escNext       = escState;
    mutedNext     = muted;
    holdValidNext = holdValid;
    errNext       = 1'b0;
    takeData      = 1'b0;
    dataSel       = SEL_RAW;
    strobes       = '0;
    strobes.sel   = SEL_RAW;

    if (accept) begin
      if (muted) begin
        if (inByte == DELIM_CODE) begin
          mutedNext      = 1'b0;
          strobes.reseed = 1'b1;
        end
      end else if (escState == ST_ESCAPED) begin
        escNext = ST_PLAIN;
        if (inByte == ESC_DELIM) begin
          takeData = 1'b1;
          dataSel  = SEL_DELIM;
        end else if (inByte == ESC_ESCAPE) begin
          takeData = 1'b1;
          dataSel  = SEL_ESCAPE;
        end else if (inByte == DELIM_CODE) begin
          errNext        = 1'b1;
          holdValidNext  = 1'b0;
          strobes.reseed = 1'b1;
        end else begin
          errNext       = 1'b1;
          holdValidNext = 1'b0;
          mutedNext     = 1'b1;
        end
      end else begin
        if (inByte == DELIM_CODE) begin
          strobes.reseed = 1'b1;
          if (holdValid) begin
            strobes.pushHold = 1'b1;
            strobes.pushLast = 1'b1;
          end
          holdValidNext = 1'b0;
        end else if (inByte == ESCAPE_CODE) begin
          escNext = ST_ESCAPED;
        end else begin
          takeData = 1'b1;
          dataSel  = SEL_RAW;
        end
      end

      if (takeData) begin
        strobes.advance  = 1'b1;
        strobes.loadHold = 1'b1;
        strobes.sel      = dataSel;
        strobes.pushHold = holdValid;
        strobes.pushLast = 1'b0;
        holdValidNext    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      escState  <= ST_PLAIN;
      muted     <= 1'b0;
      holdValid <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      escState  <= escNext;
      muted     <= mutedNext;
      holdValid <= holdValidNext;
      errPulse  <= errNext;
    end
  end

  // R3: an error never lasts beyond one cycle
  p_err_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);

  // R4: while muted nothing is held and no escape is pending
  p_mute_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    muted |-> (!holdValid && escState == ST_PLAIN));

  // R3: an error leaves no held byte behind
  p_err_drops_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !holdValid);

  // R6: a last marker is only pushed together with a reseed
  p_last_on_delim_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pushHold && strobes.pushLast) |-> strobes.reseed);

endmodule

// File: rtl/slipData.sv
module slipData
  import slipDecPkg::*;
#(
  parameter int          STATE_W = 16,
  parameter logic [15:0] TAPS    = 16'hB400,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  dpStrobe_t  strobes,
  input  logic       outReady,
  output logic       outFree,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outLast
);

  logic [7:0] key;
  logic [7:0] recovered;
  logic [7:0] holdData;

  slipKeystream #(
    .STATE_W (STATE_W),
    .KEY_W   (8),
    .TAPS    (TAPS),
    .SEED    (SEED)
  ) uKeys (
    .clk     (clk),
    .rstN    (rstN),
    .advance (strobes.advance),
    .reseed  (strobes.reseed),
    .key     (key)
  );

  always_comb begin
    unique case (strobes.sel)
      SEL_DELIM:  recovered = DELIM_CODE;
      SEL_ESCAPE: recovered = ESCAPE_CODE;
      default:    recovered = inByte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 holdData <= '0;
    else if (strobes.loadHold) holdData <= recovered ^ key;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
    end else if (strobes.pushHold) begin
      outValid <= 1'b1;
      outData  <= holdData;
      outLast  <= strobes.pushLast;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  assign outFree = !outValid || outReady;

  // R9: the control never pushes into an occupied output register
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushHold |-> outFree);

  // R9: a stalled output stays put
  p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

endmodule

// File: rtl/slipDescrambler.sv
module slipDescrambler
  import slipDecPkg::*;
#(
  parameter int          STATE_W = 16,
  parameter logic [15:0] TAPS    = 16'hB400,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       inValid,
  output logic       inReady,
  output logic [7:0] outData,
  output logic       outLast,
  output logic       outValid,
  input  logic       outReady,
  output logic       errPulse
);

  dpStrobe_t strobes;
  logic      outFree;

  slipCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inByte   (inByte),
    .inValid  (inValid),
    .outFree  (outFree),
    .inReady  (inReady),
    .strobes  (strobes),
    .errPulse (errPulse)
  );

  slipData #(
    .STATE_W (STATE_W),
    .TAPS    (TAPS),
    .SEED    (SEED)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .inByte   (inByte),
    .strobes  (strobes),
    .outReady (outReady),
    .outFree  (outFree),
    .outValid (outValid),
    .outData  (outData),
    .outLast  (outLast)
  );

  // R10: nothing is presented in the cycle right after reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    $rose(rstN) |-> (!outValid && !errPulse));

endmodule

// File: tb/tb_slipDescrambler.sv
module tb_slipDescrambler;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inByte = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] outData;
  logic       outLast;
  logic       outValid;
  logic       outReady = 1'b0;
  logic       errPulse;

  always #2.5 clk = ~clk;

  slipDescrambler dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outLast(outLast),
    .outValid(outValid), .outReady(outReady), .errPulse(errPulse)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] stream [0:16383];
  int         nStream = 0;
  logic [7:0] expD [0:8191];
  logic       expL [0:8191];
  int         nExp = 0;
  int         rdExp = 0;
  int         errExp = 0;
  int         errSeen = 0;

  function automatic logic [15:0] step8(logic [15:0] s);
    logic [15:0] t = s;
    for (int i = 0; i < 8; i++) t = {t[14:0], t[15] ^ t[13] ^ t[12] ^ t[10]};
    return t;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic putRaw(logic [7:0] b);
    stream[nStream] = b;
    nStream++;
  endtask

  task automatic putStuffed(logic [7:0] b);
    if (b == 8'hC0) begin putRaw(8'hDB); putRaw(8'hDC); end
    else if (b == 8'hDB) begin putRaw(8'hDB); putRaw(8'hDD); end
    else putRaw(b);
  endtask

  task automatic expect1(logic [7:0] d, logic l);
    expD[nExp] = d;
    expL[nExp] = l;
    nExp++;
  endtask

  // mode 0 random, 1 bad escape, 2 delimiter inside escape, 3 forced escapes, 4 constant 0xC0
  task automatic addFrame(int len, int mode);
    logic [15:0] s = 16'hACE1;
    logic [7:0]  p;
    int errPos = 0;
    if (mode == 1) errPos = (len > 0) ? int'($urandom % len) : 0;
    if (mode == 2) errPos = int'($urandom % (len + 1));
    if (mode == 1 && len == 0) mode = 0;
    for (int i = 0; i < len; i++) begin
      if (mode == 2 && i == errPos) break;
      case (mode)
        3:       p = ((i % 2) ? 8'hDB : 8'hC0) ^ s[7:0];
        4:       p = 8'hC0;
        default: p = 8'($urandom);
      endcase
      if (mode == 1 && i == errPos) begin
        putRaw(8'hDB); putRaw(8'h41);
        errExp++;
      end
      putStuffed(p ^ s[7:0]);
      s = step8(s);
      if (mode == 0 || mode >= 3) expect1(p, i == len - 1);
      else if (i < errPos - 1) expect1(p, 1'b0);
    end
    if (mode == 2) begin
      putRaw(8'hDB);
      errExp++;
    end
    putRaw(8'hC0);
  endtask

  always @(negedge clk) if (rstN && !finished && errPulse) errSeen++;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic       held;
    logic [7:0] heldD;
    logic       heldL;
    int idx;
    void'($urandom(32'd1234));

    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R10 outValid", outValid, 0);
    check("R10 errPulse", errPulse, 0);
    check("R10 inReady", inReady, 1);

    // R7: two delimiters in a row with nothing between
    outReady = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); inValid = 1'b1; inByte = 8'hC0;
    end
    @(negedge clk); inValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 empty frame output", outValid, 0);
    check("R7 empty frame error", errSeen, 0);

    addFrame(6, 3);
    addFrame(5, 4);
    addFrame(0, 0);
    addFrame(4, 2);
    addFrame(7, 0);
    addFrame(6, 1);
    addFrame(8, 0);
    addFrame(3, 2);
    addFrame(1, 0);
    for (int f = 0; f < 140; f++) begin
      int r = int'($urandom % 20);
      int len = int'($urandom % 25);
      addFrame(len, (r < 2) ? 1 : (r < 3) ? 2 : (r < 5) ? 3 : (r < 6) ? 4 : 0);
    end

    idx = 0;
    held = 1'b0;
    heldD = '0;
    heldL = 1'b0;
    while (idx < nStream || rdExp < nExp || outValid) begin
      @(negedge clk);
      #1;
      if (held) begin
        check("R9 stalled data", outData, heldD);
        check("R9 stalled last", outLast, heldL);
      end
      outReady = ($urandom % 4) != 0;
      inValid  = (idx < nStream) && (($urandom % 5) != 0);
      inByte   = (idx < nStream) ? stream[idx] : 8'h00;
      #1;
      check("R9 inReady", inReady, !outValid || outReady);
      if (outValid && outReady) begin
        if (rdExp >= nExp) check("R4 unexpected output", 1, 0);
        else begin
          check("R1/R2/R5 data", outData, expD[rdExp]);
          check("R6 last", outLast, expL[rdExp]);
          rdExp++;
        end
      end
      held  = outValid && !outReady;
      heldD = outData;
      heldL = outLast;
      if (inValid && inReady) idx++;
    end
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 all expected bytes seen", rdExp, nExp);
    check("R3/R8 error pulse count", errSeen, errExp);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule